// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one compare channel of a high-resolution event timer. A free-running 64-bit main counter arrives as an input. The channel compares it against a programmable comparator and, when the counter has reached the comparator, emits a one-cycle fire pulse towards an interrupt router, together with the routing field software stored in the channel's configuration.

The channel can run in one of two modes:

- **One-shot:** it fires once and then disarms.
- **Periodic:** each match advances the comparator by a hidden period register.

A per-channel narrow mode restricts everything to the low 32 bits of the counter. In narrow one-shot mode the channel also fires when the low word of the counter rolls over.

Software reaches the channel through a simple write port that carries 32-bit halves: the configuration word, the comparator low half and the comparator high half. The configuration and the comparator can be read back directly. For level-type channels a pending flag holds the interrupt until it is acknowledged.

Top module: `evt_tmr_channel`

## Requirements
- R1: After reset `cmp_o` is all ones, `fire_o` and `pend_o` are 0, and `cfg_o` reads 0x18: the periodic-capable bit 3 and the 64-bit-capable bit 4 are set. Both capability bits are read-only ones. The remaining configuration bits are: bit 0 level type, bit 1 enable, bit 2 periodic, bit 5 set-value, bit 6 narrow (32-bit) mode, and bits 11:7 route.
- R2: A write uses `wr_sel_i`. The code 0 writes the configuration, 1 writes the comparator low half, 2 writes the comparator high half, and 3 is no write. When the channel is armed and enabled with the global enable high, it counts as due when (counter − comparator), taken as a signed value of the active width, is zero or positive. `fire_o` is high in the cycle after the clock edge at which `count_i` was due.
- R3: In one-shot mode a comparator-match fire disarms the channel, so later due counts do not fire. A rising edge of the enable bit re-arms it. So does any comparator write while the channel is enabled.
- R4: In periodic mode with a nonzero period, every due edge adds the period to the comparator. If the comparator is still behind, it is advanced again on each following edge. Only the first of such a run of due edges fires.
- R5: In periodic mode a comparator write updates the comparator only when set-value is 1. Otherwise it updates only the matching half of the period. The set-value bit reads 0 after any comparator write.
- R6: A period half written in periodic mode has its top bit of the active width cleared. That is bit 31 of a low-half write in narrow mode, and bit 31 of a high-half write in 64-bit mode.
- R7: Selecting narrow mode clears the upper halves of the comparator and the period. In narrow mode, comparator high-half writes are ignored, and only the low 32 bits of the counter take part in matching and period adds.
- R8: In narrow one-shot mode an armed, enabled channel also fires when the counter's low word goes from 0xFFFFFFFF to 0. This fire does not disarm the channel, so the comparator match still fires afterwards.
- R9: A fire of a level-type channel sets `pend_o`. It stays set until an edge with `int_ack_i` high. An edge-type channel never sets it.
- R10: A configuration write that clears the enable bit disarms the channel and clears `pend_o` at that edge.
- R11: No fire occurs while `glb_en_i` is low, and an armed channel that is due fires once `glb_en_i` returns high. `route_o` always shows configuration bits 11:7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en_i | input | 1 | Global timer enable |
| count_i | input | 64 | Main counter value |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 config, 1 comparator low, 2 comparator high |
| wr_data_i | input | 32 | Write data |
| int_ack_i | input | 1 | Clears the level pending flag |
| fire_o | output | 1 | One-cycle expiry pulse |
| pend_o | output | 1 | Level-type pending interrupt |
| route_o | output | 5 | Route field for the interrupt router |
| cfg_o | output | 32 | Configuration readback |
| cmp_o | output | 64 | Comparator readback |

## Verification
Every result of this block is due exactly one edge after its cause:

- A write shows in `cfg_o` or `cmp_o` just after the edge that takes it.
- A due counter value presented before edge k shows as `fire_o` and, for the level type, `pend_o` after edge k.
- In a periodic catch-up, each later edge moves `cmp_o` by one more period.

The driver applies one stimulus per cycle at the falling edge and queues the state it expects after the next rising edge. The monitor pops that entry a quarter period after that rising edge, so each compare lands on the single cycle the requirements name.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int CNT_W   = 64;
  localparam int HALF_W  = CNT_W / 2;
  localparam int ROUTE_W = 5;
  localparam int CFG_W   = 7 + ROUTE_W;

  typedef enum logic [1:0] {
    SEL_CFG    = 2'd0,
    SEL_CMP_LO = 2'd1,
    SEL_CMP_HI = 2'd2,
    SEL_NONE   = 2'd3
  } wsel_e;

  typedef struct packed {
    logic [ROUTE_W-1:0] route;
    logic               narrow;
    logic               setval;
    logic               cap64;
    logic               capper;
    logic               periodic;
    logic               en;
    logic               level;
  } cfg_t;

  localparam cfg_t CFG_RST = '{route: '0, narrow: 1'b0, setval: 1'b0,
                               cap64: 1'b1, capper: 1'b1, periodic: 1'b0,
                               en: 1'b0, level: 1'b0};

  // counter has reached comparator: signed difference of the active width >= 0
  function automatic logic f_due(logic [CNT_W-1:0] c, logic [CNT_W-1:0] k, logic nar);
    logic [CNT_W-1:0] d;
    d = c - k;
    return nar ? ~d[HALF_W-1] : ~d[CNT_W-1];
  endfunction

  // comparator advanced by one period
  function automatic logic [CNT_W-1:0] f_adv(logic [CNT_W-1:0] k, logic [CNT_W-1:0] p, logic nar);
    logic [HALF_W-1:0] lo;
    lo = k[HALF_W-1:0] + p[HALF_W-1:0];
    return nar ? {{HALF_W{1'b0}}, lo} : k + p;
  endfunction

  // period half limited to half the counter range
  function automatic logic [HALF_W-1:0] f_half_mask(logic [HALF_W-1:0] d, logic top);
    return top ? {1'b0, d[HALF_W-2:0]} : d;
  endfunction

  function automatic logic f_per_nz(logic [CNT_W-1:0] p, logic nar);
    return nar ? |p[HALF_W-1:0] : |p;
  endfunction
endpackage

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [HALF_W-1:0] wr_data_i,
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  adv_val_i,
  output cfg_t              cfg_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic [CNT_W-1:0]  per_o,
  output logic              en_rise_o,
  output logic              en_fall_o,
  output logic              cmp_wr_o
);
  cfg_t             cfg_q, wcfg;
  logic [CNT_W-1:0] cmp_q, per_q;
  logic             wr_cfg, wr_lo, wr_hi, to_cmp;

  assign wr_cfg = wr_en_i && (wr_sel_i == SEL_CFG);
  assign wr_lo  = wr_en_i && (wr_sel_i == SEL_CMP_LO);
  assign wr_hi  = wr_en_i && (wr_sel_i == SEL_CMP_HI);
  assign to_cmp = !cfg_q.periodic || cfg_q.setval;

  always_comb begin
    wcfg        = cfg_t'(wr_data_i[CFG_W-1:0]);
    wcfg.capper = 1'b1;
    wcfg.cap64  = 1'b1;
  end

  assign en_rise_o = wr_cfg && wcfg.en && !cfg_q.en;
  assign en_fall_o = wr_cfg && !wcfg.en && cfg_q.en;
  assign cmp_wr_o  = wr_lo || wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      cmp_q <= '1;
      per_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= wcfg;
      if (wcfg.narrow) begin
        cmp_q[CNT_W-1:HALF_W] <= '0;
        per_q[CNT_W-1:HALF_W] <= '0;
      end
    end else if (wr_lo) begin
      if (to_cmp) cmp_q[HALF_W-1:0] <= wr_data_i;
      if (cfg_q.periodic) per_q[HALF_W-1:0] <= f_half_mask(wr_data_i, cfg_q.narrow);
      cfg_q.setval <= 1'b0;
    end else if (wr_hi) begin
      if (!cfg_q.narrow) begin
        if (to_cmp) cmp_q[CNT_W-1:HALF_W] <= wr_data_i;
        else        per_q[CNT_W-1:HALF_W] <= f_half_mask(wr_data_i, 1'b1);
      end
      cfg_q.setval <= 1'b0;
    end else if (adv_i) begin
      cmp_q <= adv_val_i;
    end
  end

  assign cfg_o = cfg_q;
  assign cmp_o = cmp_q;
  assign per_o = per_q;

  p_caps_ro_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.capper && cfg_q.cap64);
  p_setval_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_o |=> !cfg_q.setval);
  p_narrow_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.narrow |-> (cmp_q[CNT_W-1:HALF_W] == '0) && (per_q[CNT_W-1:HALF_W] == '0));
endmodule

// File: rtl/evt_tmr_match.sv
module evt_tmr_match
  import evt_tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en_i,
  input  logic [CNT_W-1:0] count_i,
  input  cfg_t             cfg_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             en_rise_i,
  input  logic             en_fall_i,
  input  logic             cmp_wr_i,
  input  logic             ack_i,
  output logic             fire_ev_o,
  output logic             adv_o,
  output logic [CNT_W-1:0] adv_val_o,
  output logic             pend_o
);
  logic              armed_q, catch_q, cnt_v_q, pend_q;
  logic [HALF_W-1:0] cnt_lo_q;
  logic              due, live, hit, wrap_ev;

  assign due     = f_due(count_i, cmp_i, cfg_i.narrow);
  assign live    = armed_q && cfg_i.en && glb_en_i;
  assign hit     = live && due && !catch_q;
  assign wrap_ev = live && cfg_i.narrow && !cfg_i.periodic && cnt_v_q
                   && (&cnt_lo_q) && (count_i[HALF_W-1:0] == '0);
  assign fire_ev_o = hit || wrap_ev;
  assign adv_o     = live && cfg_i.periodic && due && f_per_nz(per_i, cfg_i.narrow);
  assign adv_val_o = f_adv(cmp_i, per_i, cfg_i.narrow);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      catch_q  <= 1'b0;
      cnt_v_q  <= 1'b0;
      cnt_lo_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      cnt_v_q  <= 1'b1;
      cnt_lo_q <= count_i[HALF_W-1:0];
      if (en_fall_i)                          armed_q <= 1'b0;
      else if (en_rise_i || (cmp_wr_i && cfg_i.en)) armed_q <= 1'b1;
      else if (hit && !cfg_i.periodic)        armed_q <= 1'b0;
      if (en_rise_i || cmp_wr_i) catch_q <= 1'b0;
      else                       catch_q <= live && cfg_i.periodic && due;
      if (en_fall_i)                         pend_q <= 1'b0;
      else if (fire_ev_o && cfg_i.level)     pend_q <= 1'b1;
      else if (ack_i)                        pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  p_pend_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(cfg_i.level));
  p_disarm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall_i |=> !pend_q);
  p_catchup_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (catch_q && !wrap_ev) |-> !fire_ev_o);
endmodule

// File: rtl/evt_tmr_channel.sv
module evt_tmr_channel
  import evt_tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_en_i,
  input  logic [63:0]        count_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [31:0]        wr_data_i,
  input  logic               int_ack_i,
  output logic               fire_o,
  output logic               pend_o,
  output logic [4:0]         route_o,
  output logic [31:0]        cfg_o,
  output logic [63:0]        cmp_o
);
  cfg_t             cfg;
  logic [CNT_W-1:0] cmp, per, adv_val;
  logic             en_rise, en_fall, cmp_wr, adv, fire_ev, fire_q;

  evt_tmr_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .adv_i(adv), .adv_val_i(adv_val),
    .cfg_o(cfg), .cmp_o(cmp), .per_o(per),
    .en_rise_o(en_rise), .en_fall_o(en_fall), .cmp_wr_o(cmp_wr)
  );

  evt_tmr_match u_match (
    .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en_i), .count_i(count_i),
    .cfg_i(cfg), .cmp_i(cmp), .per_i(per),
    .en_rise_i(en_rise), .en_fall_i(en_fall), .cmp_wr_i(cmp_wr),
    .ack_i(int_ack_i), .fire_ev_o(fire_ev), .adv_o(adv),
    .adv_val_o(adv_val), .pend_o(pend_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fire_q <= 1'b0;
    else        fire_q <= fire_ev;
  end

  assign fire_o  = fire_q;
  assign route_o = cfg.route;
  assign cfg_o   = {{(32-CFG_W){1'b0}}, cfg};
  assign cmp_o   = cmp;

  p_fire_qualified_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(glb_en_i) && $past(cfg.en));
  p_fire_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && !$past(cfg.periodic) && !$past(cfg.narrow)) |=> !fire_o);
endmodule

// File: tb/evt_tmr_channel_bench.sv
module evt_tmr_channel_bench;
  localparam int CLK_P = 10;

  typedef struct {
    logic        fire;
    logic        pend;
    logic        ccmp;
    logic [63:0] cmp;
    logic        ccfg;
    logic [31:0] cfg;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, glb_en = 1'b1, wr_en = 1'b0, ack = 1'b0;
  logic [63:0] count = '0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic        fire, pend;
  logic [4:0]  route;
  logic [31:0] cfg;
  logic [63:0] cmp;
  exp_t        q[$];
  int          vecs = 0, bad = 0;
  logic        g_glb = 1'b1;
  logic        done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evt_tmr_channel u_evt_tmr_channel (
    .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en), .count_i(count),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .int_ack_i(ack),
    .fire_o(fire), .pend_o(pend), .route_o(route), .cfg_o(cfg), .cmp_o(cmp)
  );

  task automatic step(input logic [63:0] c, input logic [1:0] sel, input logic [31:0] d,
                      input logic a, input logic ef, input logic ep,
                      input logic cc, input logic [63:0] ec,
                      input logic cg, input logic [31:0] eg, input string tag);
    exp_t e;
    @(negedge clk);
    count = c; wr_sel = sel; wr_en = (sel != 2'd3); wr_data = d; ack = a; glb_en = g_glb;
    e.fire = ef; e.pend = ep; e.ccmp = cc; e.cmp = ec; e.ccfg = cg; e.cfg = eg; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  // monitor: compare a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vecs++;
        if (fire !== e.fire) begin
          bad++; $display("FAIL %s fire act=%0b exp=%0b", e.tag, fire, e.fire);
        end
        if (pend !== e.pend) begin
          bad++; $display("FAIL %s pend act=%0b exp=%0b", e.tag, pend, e.pend);
        end
        if (e.ccmp && cmp !== e.cmp) begin
          bad++; $display("FAIL %s cmp act=%h exp=%h", e.tag, cmp, e.cmp);
        end
        if (e.ccfg && cfg !== e.cfg) begin
          bad++; $display("FAIL %s cfg act=%h exp=%h", e.tag, cfg, e.cfg);
        end
        if (e.ccfg && route !== e.cfg[11:7]) begin
          bad++; $display("FAIL %s route act=%0d exp=%0d", e.tag, route, e.cfg[11:7]);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  localparam logic [1:0] N = 2'd3, CF = 2'd0, LO = 2'd1, HI = 2'd2;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    step(0, N, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 32'h18, "R1");
    // R2/R3 one-shot 64-bit
    step(0, LO, 100, 0, 0, 0, 1, 64'hFFFF_FFFF_0000_0064, 0, 0, "R2 cmp lo");
    step(0, HI, 0, 0, 0, 0, 1, 64'd100, 0, 0, "R2 cmp hi");
    step(0, CF, 32'h02, 0, 0, 0, 0, 0, 1, 32'h1A, "R2 enable");
    step(99, N, 0, 0, 0, 0, 0, 0, 0, 0, "R2 below");
    step(100, N, 0, 0, 1, 0, 0, 0, 0, 0, "R2 match");
    step(101, N, 0, 0, 0, 0, 0, 0, 0, 0, "R3 disarmed / R9 edge no pend");
    step(200, N, 0, 0, 0, 0, 0, 0, 0, 0, "R3 stays disarmed");
    step(200, LO, 300, 0, 0, 0, 1, 64'd300, 0, 0, "R3 rearm write");
    step(300, N, 0, 0, 1, 0, 0, 0, 0, 0, "R3 rearmed fire");
    // R4/R5 periodic 64-bit
    step(0, CF, 32'h24, 0, 0, 0, 0, 0, 1, 32'h3C, "R5 periodic setval");
    step(0, LO, 200, 0, 0, 0, 1, 64'd200, 1, 32'h1C, "R5 setval write");
    step(0, HI, 0, 0, 0, 0, 1, 64'd200, 0, 0, "R5 period hi");
    step(0, LO, 50, 0, 0, 0, 1, 64'd200, 0, 0, "R5 period lo only");
    step(0, CF, 32'h06, 0, 0, 0, 0, 0, 1, 32'h1E, "R4 enable");
    step(199, N, 0, 0, 0, 0, 1, 64'd200, 0, 0, "R4 below");
    step(200, N, 0, 0, 1, 0, 1, 64'd250, 0, 0, "R4 match adds");
    step(201, N, 0, 0, 0, 0, 1, 64'd250, 0, 0, "R4 idle");
    step(260, N, 0, 0, 1, 0, 1, 64'd300, 0, 0, "R4 second");
    step(260, N, 0, 0, 0, 0, 1, 64'd300, 0, 0, "R4 ahead");
    step(420, N, 0, 0, 1, 0, 1, 64'd350, 0, 0, "R4 catchup start");
    step(420, N, 0, 0, 0, 0, 1, 64'd400, 0, 0, "R4 catchup silent");
    step(420, N, 0, 0, 0, 0, 1, 64'd450, 0, 0, "R4 catchup silent");
    step(420, N, 0, 0, 0, 0, 1, 64'd450, 0, 0, "R4 caught up");
    // R6/R7 narrow mode
    step(0, CF, 32'h00, 0, 0, 0, 0, 0, 1, 32'h18, "R10 disable");
    step(0, HI, 5, 0, 0, 0, 1, 64'h5_0000_01C2, 0, 0, "R7 hi write 64");
    step(0, CF, 32'h64, 0, 0, 0, 1, 64'h1C2, 1, 32'h7C, "R7 truncate");
    step(0, LO, 32'hFFFF_FF00, 0, 0, 0, 1, 64'hFFFF_FF00, 1, 32'h5C, "R5 setval narrow");
    step(0, LO, 32'hFFFF_FFFF, 0, 0, 0, 1, 64'hFFFF_FF00, 0, 0, "R6 period mask");
    step(0, HI, 32'hABCD, 0, 0, 0, 1, 64'hFFFF_FF00, 0, 0, "R7 hi ignored");
    step(64'h1_FFFF_FE00, CF, 32'h46, 0, 0, 0, 0, 0, 1, 32'h5E, "R7 enable");
    step(64'h1_FFFF_FF00, N, 0, 0, 1, 0, 1, 64'h7FFF_FEFF, 0, 0, "R6 R7 masked add");
    step(64'h1_FFFF_FF00, N, 0, 0, 0, 0, 1, 64'h7FFF_FEFF, 0, 0, "R7 ahead");
    // R8 wrap
    step(64'h1_FFFF_FF00, CF, 32'h00, 0, 0, 0, 0, 0, 1, 32'h18, "R8 disable");
    step(64'h1_FFFF_FF00, CF, 32'h40, 0, 0, 0, 0, 0, 1, 32'h58, "R8 narrow oneshot");
    step(64'h1_FFFF_FF00, LO, 32'h10, 0, 0, 0, 1, 64'h10, 0, 0, "R8 cmp");
    step(64'hFFFF_FFFE, CF, 32'h42, 0, 0, 0, 0, 0, 1, 32'h5A, "R8 enable");
    step(64'hFFFF_FFFF, N, 0, 0, 0, 0, 0, 0, 0, 0, "R8 before wrap");
    step(64'h1_0000_0000, N, 0, 0, 1, 0, 0, 0, 0, 0, "R8 wrap fire");
    step(64'h1_0000_0005, N, 0, 0, 0, 0, 0, 0, 0, 0, "R8 between");
    step(64'h1_0000_0010, N, 0, 0, 1, 0, 0, 0, 0, 0, "R8 match after wrap");
    step(64'h1_0000_0011, N, 0, 0, 0, 0, 0, 0, 0, 0, "R8 done");
    // R9/R10 level pending
    step(64'h1_0000_0011, CF, 32'h43, 0, 0, 0, 0, 0, 1, 32'h5B, "R9 level");
    step(64'h1_0000_0011, LO, 32'h20, 0, 0, 0, 1, 64'h20, 0, 0, "R9 rearm");
    step(64'h1_0000_0020, N, 0, 0, 1, 1, 0, 0, 0, 0, "R9 pend set");
    step(64'h1_0000_0020, N, 0, 0, 0, 1, 0, 0, 0, 0, "R9 pend held");
    step(64'h1_0000_0020, N, 0, 1, 0, 0, 0, 0, 0, 0, "R9 ack");
    step(64'h1_0000_0020, LO, 32'h30, 0, 0, 0, 0, 0, 0, 0, "R9 rearm");
    step(64'h1_0000_0030, N, 0, 0, 1, 1, 0, 0, 0, 0, "R9 pend again");
    step(64'h1_0000_0030, CF, 32'h41, 0, 0, 0, 0, 0, 1, 32'h59, "R10 disable drops pend");
    step(64'h1_0000_0040, N, 0, 0, 0, 0, 0, 0, 0, 0, "R10 no fire");
    // R11 global enable and route
    g_glb = 1'b0;
    step(64'h1_0000_0040, CF, 32'h2C2, 0, 0, 0, 0, 0, 1, 32'h2DA, "R11 route arm");
    step(64'h1_0000_0040, N, 0, 0, 0, 0, 0, 0, 0, 0, "R11 gated");
    g_glb = 1'b1;
    step(64'h1_0000_0040, N, 0, 0, 1, 0, 0, 0, 0, 0, "R11 released");
    step(64'h1_0000_0040, N, 0, 0, 0, 0, 0, 0, 0, 0, "R11 once");
    @(posedge clk); #(CLK_P/2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule